// File: doc/BRIEF.md
# Dual-Modulus Reference and Loop Divider

This block sits between a frequency synthesizer's reference clock, an external dual-modulus prescaler and a phase/frequency detector. A programmable reference divider turns reference ticks into the comparison strobe `fr_o`. A swallow-style loop divider turns prescaler output ticks into the loop strobe `fv_o`. The loop divider has a swallow counter and a main counter, and it drives the prescaler's modulus-select line `mc_o`. The prescaler divides by P+1 while the swallow count is nonzero and by P for the rest of the main count, so the total loop ratio is N·P + A.

The whole block runs on one clock, `clk_i`. Each of the two divided domains advances only on cycles where its enable (`ref_en_i` or `pre_en_i`) is high. Software writes new ratios into staging registers through a one-word-per-cycle configuration port. Writing the reference ratio is the event that hands all three staged values to the live counters in one cycle. That hand-over waits for a cycle in which neither divider is reloading. Each counter picks up its new ratio at its own next reload, so a period that is already running always completes with one consistent ratio. A standby input holds every counter at its loaded start value and silences both strobes. When standby is released, both dividers restart in step.

Top module: `dual_mod_divider`

## Requirements
- R1: After reset the live ratios are reference 8, swallow 2 and main 16. Both strobes are low, and `mc_o` is high (nonzero swallow count).
- R2: For a live reference ratio R of 5 or more, `fr_o` is high for exactly one cycle, on every R-th cycle that has `ref_en_i` high.
- R3: With a live reference ratio of 1, `fr_o` equals `ref_en_i` in every cycle.
- R4: A reference write (`cfg_sel_i` = 0) with a value of 2, 3 or 4 is ignored: nothing is staged and nothing is committed.
- R5: Swallow writes (`cfg_sel_i` = 1) and main writes (`cfg_sel_i` = 2) only update staging registers and do not change any divide period. These writes are ignored while a commit is pending.
- R6: An accepted reference write commits the staged reference, swallow and main ratios to the live registers in the same cycle. Each divider finishes its current period with the old ratio and uses the new one from its next reload.
- R7: A commit never takes place in a cycle where `fr_o` or `fv_o` strobes. It is deferred to the first cycle with no reload.
- R8: `fv_o` strobes on every N-th cycle with `pre_en_i` high. Within each period, `mc_o` (1 = divide by P+1) is high on exactly the first A of those N ticks, for 0 ≤ A ≤ N.
- R9: A reference write is refused when the staged swallow value exceeds the staged main value, or when the staged main value is 0.
- R10: While `stby_i` is high, both strobes stay low. After release, the first `fr_o` comes on the R-th reference tick and the first `fv_o` on the N-th loop tick.
- R11: A write with `cfg_sel_i` = 3 has no effect on any ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stby_i | input | 1 | Standby: hold counters at start values, mute strobes |
| ref_en_i | input | 1 | Reference tick enable |
| pre_en_i | input | 1 | Prescaler output tick enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Target: 0 reference, 1 swallow, 2 main, 3 unused |
| cfg_data_i | input | 13 | Write data (parameter D_W) |
| fr_o | output | 1 | Divided reference strobe |
| fv_o | output | 1 | Divided loop strobe |
| mc_o | output | 1 | Prescaler modulus select, 1 = P+1 |

## Verification
The bench checks periods across a ratio change, so a design that swaps ratios in the middle of a count shows up as a wrong first period after the commit. A reference write is timed so that its commit would land on a reload tick: a design without deferral or with a shifted strobe puts the pulse in the wrong cycle or stretches the next period. The bench tests the illegal reference values, the swallow-above-main and zero-main cases, the reserved selector, and the edges A = 0 and A = N of the modulus pattern. Each would corrupt the period or the `mc_o` count if it were accepted or decoded wrongly. The ratio-1 pass-through and the restart from standby are checked cycle by cycle, where an off-by-one count shifts the first strobe.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  typedef enum logic [1:0] {
    SEL_R   = 2'd0,
    SEL_A   = 2'd1,
    SEL_N   = 2'd2,
    SEL_RSV = 2'd3
  } cfg_sel_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dmd_cfg_stage.sv
module dmd_cfg_stage
  import dmd_pkg::*;
#(
  parameter int unsigned R_W   = 13,
  parameter int unsigned A_W   = 8,
  parameter int unsigned N_W   = 10,
  parameter int unsigned D_W   = 13,
  parameter int unsigned R_DEF = 8,
  parameter int unsigned A_DEF = 2,
  parameter int unsigned N_DEF = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  cfg_sel_e       sel_i,
  input  logic [D_W-1:0] data_i,
  input  logic           r_busy_i,
  input  logic           l_busy_i,
  output logic [R_W-1:0] r_act_o,
  output logic [A_W-1:0] a_act_o,
  output logic [N_W-1:0] n_act_o
);

  localparam int unsigned     LW      = ((A_W > N_W) ? A_W : N_W) + 1;
  localparam logic [D_W-1:0]  R_MAX   = D_W'((64'd1 << R_W) - 64'd1);
  localparam logic [D_W-1:0]  R_LOWOK = D_W'(5);

  logic [R_W-1:0] r_stg_q;
  logic [A_W-1:0] a_stg_q;
  logic [N_W-1:0] n_stg_q;
  logic           pend_q;
  logic           r_ok, loop_ok, commit;

  always_comb begin
    r_ok    = (data_i == D_W'(1)) || ((data_i >= R_LOWOK) && (data_i <= R_MAX));
    loop_ok = (LW'(a_stg_q) <= LW'(n_stg_q)) && (n_stg_q != '0);
    // hand-over only in a cycle where no counter reloads
    commit  = pend_q && !r_busy_i && !l_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_stg_q <= R_W'(R_DEF);
      a_stg_q <= A_W'(A_DEF);
      n_stg_q <= N_W'(N_DEF);
      r_act_o <= R_W'(R_DEF);
      a_act_o <= A_W'(A_DEF);
      n_act_o <= N_W'(N_DEF);
      pend_q  <= 1'b0;
    end else begin
      if (commit) begin
        r_act_o <= r_stg_q;
        a_act_o <= a_stg_q;
        n_act_o <= n_stg_q;
        pend_q  <= 1'b0;
      end
      if (we_i) begin
        case (sel_i)
          SEL_R: if (r_ok && loop_ok) begin
            r_stg_q <= data_i[R_W-1:0];
            pend_q  <= 1'b1;
          end
          SEL_A: if (!pend_q) a_stg_q <= data_i[A_W-1:0];
          SEL_N: if (!pend_q) n_stg_q <= data_i[N_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R4: live reference ratio is never in the illegal 2..4 band
  a_r4_ref_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_act_o == R_W'(1)) || (r_act_o >= R_W'(5)));

  // R9: live swallow count never exceeds live main count, main nonzero
  a_r9_loop_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LW'(a_act_o) <= LW'(n_act_o)) && (n_act_o != '0));

endmodule

// File: rtl/dmd_ref_div.sv
module dmd_ref_div #(
  parameter int unsigned R_W   = 13,
  parameter int unsigned R_DEF = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stby_i,
  input  logic           tick_i,
  input  logic [R_W-1:0] ratio_i,
  output logic           fr_o,
  output logic           busy_o
);

  logic [R_W-1:0] cnt_q;
  logic           term;

  always_comb begin
    term   = (cnt_q == '0);
    busy_o = tick_i && term && !stby_i;
  end

  // ratio 1 keeps cnt_q at 0, so every tick strobes
  assign fr_o = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= R_W'(R_DEF - 1);
    end else if (stby_i) begin
      cnt_q <= ratio_i - R_W'(1);
    end else if (tick_i) begin
      if (term) cnt_q <= ratio_i - R_W'(1);
      else      cnt_q <= cnt_q - R_W'(1);
    end
  end

  // R2: a strobe starts a fresh period of the live ratio
  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |=> (cnt_q == $past(ratio_i) - R_W'(1)));

endmodule

// File: rtl/dmd_loop_div.sv
module dmd_loop_div #(
  parameter int unsigned A_W   = 8,
  parameter int unsigned N_W   = 10,
  parameter int unsigned A_DEF = 2,
  parameter int unsigned N_DEF = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stby_i,
  input  logic           tick_i,
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  output logic           fv_o,
  output logic           mc_o,
  output logic           busy_o
);

  localparam int unsigned LW = ((A_W > N_W) ? A_W : N_W) + 1;

  logic [N_W-1:0] n_cnt_q;
  logic [A_W-1:0] a_cnt_q;
  logic           term;

  always_comb begin
    term   = (n_cnt_q == '0);
    busy_o = tick_i && term && !stby_i;
    mc_o   = (a_cnt_q != '0);
  end

  assign fv_o = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_cnt_q <= N_W'(N_DEF - 1);
      a_cnt_q <= A_W'(A_DEF);
    end else if (stby_i) begin
      n_cnt_q <= n_i - N_W'(1);
      a_cnt_q <= a_i;
    end else if (tick_i) begin
      if (term) begin
        n_cnt_q <= n_i - N_W'(1);
        a_cnt_q <= a_i;
      end else begin
        n_cnt_q <= n_cnt_q - N_W'(1);
        if (a_cnt_q != '0) a_cnt_q <= a_cnt_q - A_W'(1);
      end
    end
  end

  // R8: a loop strobe reloads both counts from the live ratios
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_o |=> (n_cnt_q == $past(n_i) - N_W'(1)) && (a_cnt_q == $past(a_i)));

  // R8: swallow phase never outlasts the main count
  a_r8_swallow_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LW'(a_cnt_q) <= LW'(n_cnt_q) + LW'(1));

endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider
  import dmd_pkg::*;
#(
  parameter int unsigned R_W   = 13,
  parameter int unsigned A_W   = 8,
  parameter int unsigned N_W   = 10,
  parameter int unsigned R_DEF = 8,
  parameter int unsigned A_DEF = 2,
  parameter int unsigned N_DEF = 16,
  localparam int unsigned D_W  = max3(R_W, A_W, N_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stby_i,
  input  logic           ref_en_i,
  input  logic           pre_en_i,
  input  logic           cfg_we_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [D_W-1:0] cfg_data_i,
  output logic           fr_o,
  output logic           fv_o,
  output logic           mc_o
);

  logic [R_W-1:0] r_act;
  logic [A_W-1:0] a_act;
  logic [N_W-1:0] n_act;
  logic           r_busy, l_busy;

  dmd_cfg_stage #(
    .R_W(R_W), .A_W(A_W), .N_W(N_W), .D_W(D_W),
    .R_DEF(R_DEF), .A_DEF(A_DEF), .N_DEF(N_DEF)
  ) i_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_e'(cfg_sel_i)),
    .data_i   (cfg_data_i),
    .r_busy_i (r_busy),
    .l_busy_i (l_busy),
    .r_act_o  (r_act),
    .a_act_o  (a_act),
    .n_act_o  (n_act)
  );

  dmd_ref_div #(.R_W(R_W), .R_DEF(R_DEF)) i_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stby_i  (stby_i),
    .tick_i  (ref_en_i),
    .ratio_i (r_act),
    .fr_o    (fr_o),
    .busy_o  (r_busy)
  );

  dmd_loop_div #(.A_W(A_W), .N_W(N_W), .A_DEF(A_DEF), .N_DEF(N_DEF)) i_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stby_i (stby_i),
    .tick_i (pre_en_i),
    .a_i    (a_act),
    .n_i    (n_act),
    .fv_o   (fv_o),
    .mc_o   (mc_o),
    .busy_o (l_busy)
  );

  // R7: live ratios do not move in the cycle after a reload strobe decision
  a_r7_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |=> $stable(r_act));

  a_r7_loop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_o |=> ($stable(a_act) && $stable(n_act)));

  // R10: standby mutes both strobes
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |-> (!fr_o && !fv_o));

endmodule

// File: tb/test_dual_mod_divider.sv
module test_dual_mod_divider;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stby = 1'b0;
  logic        ref_en = 1'b0;
  logic        pre_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [12:0] cfg_data = '0;
  logic        fr, fv, mc;

  int n_checks = 0;
  int n_errors = 0;
  logic s_fr, s_fv, s_mc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mod_divider i_dual_mod_divider (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .stby_i     (stby),
    .ref_en_i   (ref_en),
    .pre_en_i   (pre_en),
    .cfg_we_i   (cfg_we),
    .cfg_sel_i  (cfg_sel),
    .cfg_data_i (cfg_data),
    .fr_o       (fr),
    .fv_o       (fv),
    .mc_o       (mc)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic re, input logic pe);
    @(negedge clk);
    ref_en = re;
    pre_en = pe;
    #1;
    s_fr = fr;
    s_fv = fv;
    s_mc = mc;
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input int d);
    @(negedge clk);
    ref_en = 1'b0; pre_en = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = 13'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure_fr(output int p);
    p = 0;
    for (int i = 0; i < 5000; i++) begin
      step(1'b1, 1'b0);
      p++;
      if (s_fr) break;
    end
  endtask

  task automatic measure_fv(output int p, output int m);
    p = 0; m = 0;
    for (int i = 0; i < 5000; i++) begin
      step(1'b0, 1'b1);
      p++;
      if (s_mc) m++;
      if (s_fv) break;
    end
  endtask

  task automatic t_reset();
    int p, m;
    check_eq("R1 fr low after reset", int'(fr), 0);
    check_eq("R1 fv low after reset", int'(fv), 0);
    check_eq("R1 mc high after reset", int'(mc), 1);
    measure_fr(p); check_eq("R1 first ref period", p, 8);
    measure_fr(p); check_eq("R2 ref period", p, 8);
    measure_fv(p, m); check_eq("R1 first loop period", p, 16);
    check_eq("R1 default swallow ticks", m, 2);
    measure_fv(p, m); check_eq("R8 loop period", p, 16);
  endtask

  task automatic t_stage_commit();
    int p, m;
    cfg_wr(2'd2, 12);
    cfg_wr(2'd1, 1);
    measure_fv(p, m);
    check_eq("R5 staged main no effect", p, 16);
    check_eq("R5 staged swallow no effect", m, 2);
    measure_fr(p); check_eq("R5 ref unchanged", p, 8);
    cfg_wr(2'd0, 6);
    measure_fr(p); check_eq("R6 ref old period completes", p, 8);
    measure_fr(p); check_eq("R6 ref new period", p, 6);
    measure_fv(p, m); check_eq("R6 loop old period completes", p, 16);
    measure_fv(p, m); check_eq("R6 loop new period", p, 12);
    check_eq("R6 swallow committed together", m, 1);
  endtask

  task automatic t_illegal_ref();
    int p;
    for (int v = 2; v <= 4; v++) begin
      cfg_wr(2'd0, v);
      measure_fr(p); check_eq("R4 illegal ref ignored", p, 6);
      measure_fr(p); check_eq("R4 illegal ref ignored", p, 6);
    end
  endtask

  task automatic t_loop_guard();
    int p;
    cfg_wr(2'd1, 20);
    cfg_wr(2'd0, 9);
    measure_fr(p); check_eq("R9 swallow>main refused", p, 6);
    measure_fr(p); check_eq("R9 swallow>main refused", p, 6);
    cfg_wr(2'd1, 1);
    cfg_wr(2'd2, 0);
    cfg_wr(2'd0, 9);
    measure_fr(p); check_eq("R9 zero main refused", p, 6);
    measure_fr(p); check_eq("R9 zero main refused", p, 6);
    cfg_wr(2'd2, 12);
  endtask

  task automatic t_reserved();
    int p, m;
    cfg_wr(2'd3, 5);
    measure_fr(p); check_eq("R11 reserved select", p, 6);
    measure_fr(p); check_eq("R11 reserved select", p, 6);
    measure_fv(p, m); check_eq("R11 reserved select loop", p, 12);
  endtask

  task automatic t_swallow();
    int p, m;
    cfg_wr(2'd1, 3);
    cfg_wr(2'd0, 6);
    measure_fv(p, m); check_eq("R6 loop old period", p, 12);
    for (int i = 1; i <= 12; i++) begin
      step(1'b0, 1'b1);
      check_eq("R8 modulus pattern", int'(s_mc), (i <= 3) ? 1 : 0);
      check_eq("R8 loop strobe position", int'(s_fv), (i == 12) ? 1 : 0);
    end
    cfg_wr(2'd1, 12);
    cfg_wr(2'd0, 6);
    measure_fv(p, m); check_eq("R8 swallow 3 count", m, 3);
    measure_fv(p, m); check_eq("R8 A equals N period", p, 12);
    check_eq("R8 A equals N swallow ticks", m, 12);
    cfg_wr(2'd1, 0);
    cfg_wr(2'd0, 6);
    measure_fv(p, m); check_eq("R8 old swallow 12", m, 12);
    measure_fv(p, m); check_eq("R8 A zero period", p, 12);
    check_eq("R8 A zero swallow ticks", m, 0);
  endtask

  task automatic t_defer();
    int p;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0);
      check_eq("R2 no early strobe", int'(s_fr), 0);
    end
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 13'd5;
    ref_en = 1'b1; pre_en = 1'b0;
    #1 check_eq("R7 write cycle no strobe", int'(fr), 0);
    @(negedge clk);
    cfg_we = 1'b0; ref_en = 1'b1;
    #1 check_eq("R7 reload strobe in place", int'(fr), 1);
    @(negedge clk);
    ref_en = 1'b0;
    measure_fr(p); check_eq("R7 period after deferred commit", p, 6);
    measure_fr(p); check_eq("R7 new ratio live", p, 5);
  endtask

  task automatic t_passthru();
    int p;
    cfg_wr(2'd0, 1);
    measure_fr(p); check_eq("R6 old period before ratio 1", p, 5);
    for (int i = 0; i < 16; i++) begin
      logic re;
      re = ((i % 3) != 1);
      step(re, 1'b0);
      check_eq("R3 ratio 1 pass-through", int'(s_fr), int'(re));
    end
    cfg_wr(2'd0, 5);
    measure_fr(p); check_eq("R6 leave ratio 1", p, 1);
    measure_fr(p); check_eq("R2 ratio 5 period", p, 5);
  endtask

  task automatic t_standby();
    int first_fr, first_fv;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    @(negedge clk);
    stby = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1);
      check_eq("R10 fr muted", int'(s_fr), 0);
      check_eq("R10 fv muted", int'(s_fv), 0);
    end
    @(negedge clk);
    stby = 1'b0; ref_en = 1'b0; pre_en = 1'b0;
    first_fr = 0; first_fv = 0;
    for (int i = 1; i <= 40; i++) begin
      step(1'b1, 1'b1);
      if (s_fr && first_fr == 0) first_fr = i;
      if (s_fv && first_fv == 0) first_fv = i;
    end
    check_eq("R10 first fr after release", first_fr, 5);
    check_eq("R10 first fv after release", first_fv, 12);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_stage_commit();
    t_illegal_ref();
    t_loop_guard();
    t_reserved();
    t_swallow();
    t_defer();
    t_passthru();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule